// File: doc/BRIEF.md
# Gated Peripheral Clock Prescaler

This block turns one oscillator clock into two kinds of timing signal for a small microcontroller. A CPU clock enable runs at half the input rate and toggles on every input cycle from reset onward. Alongside it, a free-running 12-bit binary counter drives thirteen peripheral tap strobes. Tap 0 is the undivided rate, and tap k pulses once every 2^k input cycles, up to 1/4096 of the input rate. Every tap is a one-cycle clock-enable strobe in the input clock domain, not a derived clock.

A write-only control register sits on a byte-wide write port at address 0xC7. Its bit 4 is the peripheral enable and lets all taps run or holds them all low together. While the taps are held, the counter keeps running, so turning them back on resumes them in the same phase they would have had without the pause. The other implemented bits of the register (5:0) are simply stored. Bits 7:6 do not exist and always appear as zero on the register copy output, which lets the value be observed.

The enable is kept by a two-state machine. GATE_RUN passes the taps through, and a write to 0xC7 with bit 4 = 0 moves it to GATE_HALT. GATE_HALT forces every tap low, and a write to 0xC7 with bit 4 = 1 moves it back to GATE_RUN. It comes out of reset in GATE_RUN. The CPU enable comes from a second two-state machine. PH_LOW (cpu_ce = 0) always moves to PH_HIGH (cpu_ce = 1), and PH_HIGH always moves back to PH_LOW. It comes out of reset in PH_LOW.

Top module: `perclk_prescaler`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, cpu_ce is 0, tap_ce is 13'b0000000000001 and ctrl_q is 8'h37.
- R2: With n the number of rising edges since reset was released, cpu_ce equals n mod 2. This holds whatever the enable bit is.
- R3: While ctrl_q bit 4 is 1, tap_ce[0] is 1 on every cycle.
- R4: For k from 1 to 12, tap_ce[k] is 1 exactly when ctrl_q bit 4 is 1 and n mod 2^k equals 2^k-1. A set tap_ce[k] therefore implies a set tap_ce[k-1].
- R5: A write with wr_en = 1 and wr_addr = 8'hC7 loads wr_data into ctrl_q with bits 7:6 cleared. The new value shows after the capturing edge.
- R6: While ctrl_q bit 4 is 0, all of tap_ce is 0.
- R7: The counter advances on every cycle while the taps are held. After a write sets bit 4 again, the taps follow the R4 formula using the unbroken count n.
- R8: A write with wr_en = 0, or with wr_addr other than 8'hC7, changes neither ctrl_q nor tap_ce.
- R9: A change of bit 4 takes effect on tap_ce in the cycle that directly follows the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Oscillator input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| wr_en | input | 1 | Register write strobe |
| cpu_ce | output | 1 | CPU clock enable at half the input rate |
| tap_ce | output | 13 | Peripheral tap strobes; bit k at 1/2^k of the input rate |
| ctrl_q | output | 8 | Control register copy; bits 7:6 are always zero |

## Verification
Every output is a function of registers only, with no input-to-output path. The counter, the CPU phase and the control register each change on the rising edge that samples their input, so each result is due in the cycle right after that edge. The bench drives inputs on the falling edge and compares outputs on the next falling edge. It keeps its own count n of rising edges since reset, and from n and its model of the enable bit it works out the expected cpu_ce and tap vector. It compares these on every cycle of a sweep longer than the full 4096-cycle period, through a hold, through ignored writes and after re-enable.

// File: rtl/psc_pkg.sv
package psc_pkg;
    typedef enum logic {
        GATE_RUN  = 1'b0,
        GATE_HALT = 1'b1
    } gate_state_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } cpu_phase_t;
endpackage

// File: rtl/psc_counter.sv
module psc_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q
);
    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            armed <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            armed <= 1'b1;
        end
    end

    // R7: the count advances every cycle, gated or not
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/psc_cpu_phase.sv
module psc_cpu_phase
    import psc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic cpu_ce
);
    cpu_phase_t state_q, state_d;
    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_LOW;
            armed   <= 1'b0;
        end else begin
            state_q <= state_d;
            armed   <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  state_d = PH_HIGH;
            PH_HIGH: state_d = PH_LOW;
        endcase
    end

    always_comb begin
        cpu_ce = (state_q == PH_HIGH);
    end

    assert_cpu_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> cpu_ce != $past(cpu_ce));
endmodule

// File: rtl/psc_ctrl_reg.sv
module psc_ctrl_reg
    import psc_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hC7,
    parameter int              EN_BIT    = 4,
    parameter logic [DATA_W-1:0] CTRL_RST  = 8'h37,
    parameter logic [DATA_W-1:0] IMPL_MASK = 8'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              gate_on
);
    gate_state_t       state_q, state_d;
    logic [DATA_W-1:0] bits_q;
    logic              hit;

    assign hit = wr_en && (wr_addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTRL_RST[EN_BIT] ? GATE_RUN : GATE_HALT;
            bits_q  <= CTRL_RST & IMPL_MASK;
        end else begin
            state_q <= state_d;
            if (hit) bits_q <= wr_data & IMPL_MASK;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_RUN:  if (hit && !wr_data[EN_BIT]) state_d = GATE_HALT;
            GATE_HALT: if (hit &&  wr_data[EN_BIT]) state_d = GATE_RUN;
        endcase
    end

    always_comb begin
        gate_on        = (state_q == GATE_RUN);
        ctrl_q         = bits_q;
        ctrl_q[EN_BIT] = gate_on;
    end

    assert_write_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ctrl_q == ($past(wr_data) & IMPL_MASK));
    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~IMPL_MASK) == '0);
    assert_ignore_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(ctrl_q));
endmodule

// File: rtl/psc_tap_gate.sv
module psc_tap_gate #(
    parameter int CNT_W    = 12,
    parameter int NUM_TAPS = CNT_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    cnt_q,
    input  logic                gate_on,
    output logic [NUM_TAPS-1:0] tap_ce
);
    genvar k;
    generate
        for (k = 0; k < NUM_TAPS; k++) begin : g_tap
            if (k == 0) begin : g_undiv
                assign tap_ce[k] = gate_on;
            end else begin : g_div
                assign tap_ce[k] = gate_on & (&cnt_q[k-1:0]);
            end
            if (k >= 2) begin : g_nest
                // R4: a slower tap fires only together with the next faster one
                assert_tap_nest_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    tap_ce[k] |-> tap_ce[k-1]);
            end
        end
    endgenerate
endmodule

// File: rtl/perclk_prescaler.sv
module perclk_prescaler #(
    parameter int                CNT_W     = 12,
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hC7,
    parameter int                EN_BIT    = 4,
    parameter logic [DATA_W-1:0] CTRL_RST  = 8'h37,
    parameter logic [DATA_W-1:0] IMPL_MASK = 8'h3F,
    localparam int               NUM_TAPS  = CNT_W + 1
) (
    input  logic                clk_in,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                wr_en,
    output logic                cpu_ce,
    output logic [NUM_TAPS-1:0] tap_ce,
    output logic [DATA_W-1:0]   ctrl_q
);
    logic [CNT_W-1:0] cnt_q;
    logic             gate_on;

    psc_counter #(.CNT_W(CNT_W)) i_counter (
        .clk   (clk_in),
        .rst_n (rst_n),
        .cnt_q (cnt_q)
    );

    psc_cpu_phase i_cpu_phase (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .cpu_ce (cpu_ce)
    );

    psc_ctrl_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR),
        .EN_BIT    (EN_BIT),
        .CTRL_RST  (CTRL_RST),
        .IMPL_MASK (IMPL_MASK)
    ) i_ctrl (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_en   (wr_en),
        .ctrl_q  (ctrl_q),
        .gate_on (gate_on)
    );

    psc_tap_gate #(.CNT_W(CNT_W), .NUM_TAPS(NUM_TAPS)) i_taps (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .cnt_q   (cnt_q),
        .gate_on (gate_on),
        .tap_ce  (tap_ce)
    );

    assert_cpu_count_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
        cpu_ce == cnt_q[0]);
    assert_tap0_run_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        ctrl_q[EN_BIT] |-> tap_ce[0]);
    assert_halt_quiet_R6: assert property (@(posedge clk_in) disable iff (!rst_n)
        !ctrl_q[EN_BIT] |-> tap_ce == '0);
endmodule

// File: tb/test_perclk_prescaler.sv
module test_perclk_prescaler;
    logic        clk_in = 1'b0;
    logic        rst_n  = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_en   = 1'b0;
    logic        cpu_ce;
    logic [12:0] tap_ce;
    logic [7:0]  ctrl_q;

    int total = 0;
    int bad   = 0;
    int n     = 0;
    logic       exp_en   = 1'b1;
    logic [7:0] exp_ctrl = 8'h37;
    bit done = 0;

    always #4 clk_in = ~clk_in;

    perclk_prescaler i_perclk_prescaler (
        .clk_in (clk_in), .rst_n (rst_n), .wr_addr (wr_addr), .wr_data (wr_data),
        .wr_en (wr_en), .cpu_ce (cpu_ce), .tap_ce (tap_ce), .ctrl_q (ctrl_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s n=%0d actual=%h expected=%h", req, n, act, exp);
        end
    endtask

    function automatic logic [12:1] exp_taps(input int cyc, input logic en);
        logic [12:1] e;
        for (int k = 1; k <= 12; k++)
            e[k] = en && ((cyc % (1 << k)) == ((1 << k) - 1));
        return e;
    endfunction

    task automatic step();
        @(posedge clk_in);
        n++;
        @(negedge clk_in);
    endtask

    task automatic check_all(input string ctrl_req);
        chk("R2 cpu_ce", {31'b0, cpu_ce}, (n % 2));
        if (exp_en) chk("R3 tap0", {31'b0, tap_ce[0]}, 1);
        else        chk("R6 tap0 held", {31'b0, tap_ce[0]}, 0);
        if (exp_en) chk("R4/R7 divided taps", {20'b0, tap_ce[12:1]}, {20'b0, exp_taps(n, 1'b1)});
        else        chk("R6 divided taps held", {20'b0, tap_ce[12:1]}, 0);
        chk(ctrl_req, {24'b0, ctrl_q}, {24'b0, exp_ctrl});
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d, input logic en);
        wr_addr = a; wr_data = d; wr_en = en;
        step();
        wr_en = 1'b0;
        if (en && a == 8'hC7) begin
            exp_ctrl = d & 8'h3F;
            exp_en   = d[4];
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk_in);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_in);
        // R1: values held during reset
        chk("R1 cpu_ce in reset", {31'b0, cpu_ce}, 0);
        chk("R1 taps in reset", {19'b0, tap_ce}, 13'h0001);
        chk("R1 ctrl_q in reset", {24'b0, ctrl_q}, 8'h37);
        rst_n = 1'b1;
        n = 0;
        check_all("R1 ctrl_q after release");

        // R2 R3 R4: full sweep beyond the longest tap period
        for (int i = 0; i < 8300; i++) begin
            step();
            check_all("R8 ctrl_q idle");
        end

        // R5 R6 R9: clear the enable, upper bits written as ones
        write_reg(8'hC7, 8'hEF, 1'b1);
        check_all("R5 ctrl_q load masked");
        for (int i = 0; i < 300; i++) begin
            step();
            check_all("R5 ctrl_q hold");
        end

        // R8: foreign address and missing strobe
        write_reg(8'hC6, 8'hFF, 1'b1);
        check_all("R8 foreign address");
        write_reg(8'h47, 8'h10, 1'b1);
        check_all("R8 foreign address high bit");
        write_reg(8'hC7, 8'hFF, 1'b0);
        check_all("R8 no strobe");
        for (int i = 0; i < 50; i++) begin
            step();
            check_all("R8 ctrl_q after ignored");
        end

        // R7 R9: re-enable, taps must follow unbroken count
        write_reg(8'hC7, 8'h10, 1'b1);
        check_all("R9 ctrl_q reenable");
        for (int i = 0; i < 4200; i++) begin
            step();
            check_all("R7 ctrl_q after reenable");
        end

        // R9: disable at a cycle where many taps would fire
        while ((n % 256) != 254) begin
            step();
            check_all("R7 ctrl_q align");
        end
        write_reg(8'hC7, 8'h00, 1'b1);
        check_all("R9 ctrl_q disable at tap edge");
        write_reg(8'hC7, 8'h3F, 1'b1);
        check_all("R9 ctrl_q all implemented bits");
        for (int i = 0; i < 600; i++) begin
            step();
            check_all("R4 ctrl_q tail");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule